// File: doc/BRIEF.md
# Scaled-Index Shift-and-Add Unit

This execution unit computes `A + (B << m)` on 64-bit integers, where the shift `m` runs from one to four places. It serves address scaling, where an index is multiplied by 2, 4, 8 or 16 and then added to a base. The operand that gets shifted can be taken three ways. It can be the full 64-bit B. It can be the low half of B with sign extension. It can be the low half of B with zero extension. In both half-width forms the upper half of B is never read.

A small decoder splits an 11-bit extended opcode field into three parts: the shift selector, the variant and a record flag. When the record flag is set, the unit also writes a 4-bit condition field. That field holds three bits from a signed compare of the result against zero, plus a copied summary-overflow bit. A variant code the decoder does not recognise raises an illegal-instruction pulse, and no result is produced for it.

Operands are taken in on a valid/ready handshake. The result appears one cycle later from registers, and it is held until the consumer accepts it.

Top module: `scaled_add_unit`

## Requirements
- R1: After reset `out_valid_o` and `illegal_o` are low and `in_ready_o` is high.
- R2: The opcode field is split as follows: `xo_i[10:9]` is the shift selector SH, with `xo_i[10]` as its MSB; `xo_i[8:1]` is the variant code; `xo_i[0]` is the record flag. The shift is SH+1 places, so it runs 1..4 and is never zero.
- R3: With variant code 8'b01101110 (full width), `res_o` is (B shifted left by SH+1, zero filled, top bits dropped) plus A, modulo 2^64.
- R4: With variant code 8'b10101110 (signed word), B is first replaced by B[31:0] sign-extended from bit 31, and then the result of R3 is formed.
- R5: With variant code 8'b11101110 (unsigned word), B is first replaced by B[31:0] zero-extended, and then the result of R3 is formed.
- R6: In both word variants, B[63:32] has no effect on `res_o` or `cr_o`.
- R7: Any other variant code is illegal. `illegal_o` is high for exactly the one cycle after acceptance, and `out_valid_o` stays low for that operation.
- R8: `cr_o` is {LT, GT, EQ, SO}, MSB first. LT is set when the result is negative as a signed number, GT when it is positive, and EQ when it is zero. SO is `so_i` as sampled at acceptance. `cr_we_o` equals the record flag.
- R9: An operation is accepted on a clock edge where `in_valid_i` and `in_ready_o` are both high. Its result is valid from the next cycle, and it holds stable while `out_ready_i` is low. `in_ready_o` is `!out_valid_o || out_ready_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| in_valid_i | input | 1 | Operation offered |
| in_ready_o | output | 1 | Unit can accept an operation |
| xo_i | input | 11 | Extended opcode field: SH, variant, record flag |
| a_i | input | 64 | Addend A |
| b_i | input | 64 | Operand B, shifted |
| so_i | input | 1 | Summary-overflow value copied into the condition field |
| out_valid_o | output | 1 | Result valid |
| out_ready_i | input | 1 | Consumer accepts result |
| res_o | output | 64 | Result |
| cr_o | output | 4 | Condition field {LT,GT,EQ,SO} |
| cr_we_o | output | 1 | Condition field write enable |
| illegal_o | output | 1 | Illegal variant pulse |

## Verification
The bench sweeps every SH value for each variant. It uses B values with bit 31 set and with bit 31 clear, and it uses A values that make the sum wrap past 2^64.

Each corner case catches a specific defect:
- A shift off by one (SH instead of SH+1) doubles or halves every result.
- Swapped extension modes differ only when bit 31 is set.
- A word variant that leaks B[63:32] shows up when the same low word is paired with different upper junk.

Condition-field checks cover negative, positive and exactly-zero sums. These catch a compare that treats the result as unsigned or that ignores the zero case. Illegal codes and a stalled consumer are also driven. They expose a design that emits a result for a bad opcode or that lets the held output change.

// File: rtl/scadd_pkg.sv
package scadd_pkg;
  localparam int unsigned XO_W  = 11;
  localparam int unsigned SH_W  = 2;
  localparam int unsigned VAR_W = 8;

  localparam logic [VAR_W-1:0] CODE_FULL  = 8'b01101110;
  localparam logic [VAR_W-1:0] CODE_SWORD = 8'b10101110;
  localparam logic [VAR_W-1:0] CODE_UWORD = 8'b11101110;

  typedef enum logic [1:0] {
    VAR_FULL  = 2'd0,
    VAR_SWORD = 2'd1,
    VAR_UWORD = 2'd2,
    VAR_NONE  = 2'd3
  } variant_e;
endpackage

// File: rtl/scadd_decode.sv
module scadd_decode
  import scadd_pkg::*;
(
  input  logic [XO_W-1:0] xo_i,
  output variant_e        variant_o,
  output logic [SH_W-1:0] sh_o,
  output logic            rc_o,
  output logic            legal_o
);
  logic [VAR_W-1:0] code;

  assign sh_o = xo_i[XO_W-1 -: SH_W];
  assign code = xo_i[VAR_W:1];
  assign rc_o = xo_i[0];

  always_comb begin
    unique case (code)
      CODE_FULL:  variant_o = VAR_FULL;
      CODE_SWORD: variant_o = VAR_SWORD;
      CODE_UWORD: variant_o = VAR_UWORD;
      default:    variant_o = VAR_NONE;
    endcase
  end

  assign legal_o = (variant_o != VAR_NONE);
endmodule

// File: rtl/scadd_datapath.sv
module scadd_datapath
  import scadd_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  variant_e        variant_i,
  input  logic [SH_W-1:0] sh_i,
  input  logic            so_i,
  output logic [XLEN-1:0] sum_o,
  output logic [3:0]      cr_o
);
  localparam int unsigned HALF  = XLEN / 2;
  localparam int unsigned AMT_W = SH_W + 1;

  logic [XLEN-1:0]  b_ext;
  logic [AMT_W-1:0] amt;
  logic             lt, eq;

  always_comb begin
    unique case (variant_i)
      VAR_SWORD: b_ext = {{HALF{b_i[HALF-1]}}, b_i[HALF-1:0]};
      VAR_UWORD: b_ext = {{HALF{1'b0}}, b_i[HALF-1:0]};
      default:   b_ext = b_i;
    endcase
  end

  // encoded field plus one: never a zero shift
  assign amt   = {1'b0, sh_i} + AMT_W'(1);
  assign sum_o = (b_ext << amt) + a_i;

  assign lt   = sum_o[XLEN-1];
  assign eq   = (sum_o == '0);
  assign cr_o = {lt, ~lt & ~eq, eq, so_i};

  // R3: shift of at least one leaves A's low bit untouched
  always_comb begin
    a_r3_low_bit_from_a: assert (sum_o[0] == a_i[0]);
  end
endmodule

// File: rtl/scaled_add_unit.sv
module scaled_add_unit
  import scadd_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            in_valid_i,
  output logic            in_ready_o,
  input  logic [XO_W-1:0] xo_i,
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  logic            so_i,
  output logic            out_valid_o,
  input  logic            out_ready_i,
  output logic [XLEN-1:0] res_o,
  output logic [3:0]      cr_o,
  output logic            cr_we_o,
  output logic            illegal_o
);
  variant_e        variant;
  logic [SH_W-1:0] sh;
  logic            rc, legal, fire;
  logic [XLEN-1:0] sum;
  logic [3:0]      cr_next;

  logic            valid_q, illegal_q, we_q;
  logic [XLEN-1:0] res_q;
  logic [3:0]      cr_q;

  scadd_decode u_decode (
    .xo_i      (xo_i),
    .variant_o (variant),
    .sh_o      (sh),
    .rc_o      (rc),
    .legal_o   (legal)
  );

  scadd_datapath #(.XLEN(XLEN)) u_datapath (
    .a_i       (a_i),
    .b_i       (b_i),
    .variant_i (variant),
    .sh_i      (sh),
    .so_i      (so_i),
    .sum_o     (sum),
    .cr_o      (cr_next)
  );

  assign in_ready_o = ~valid_q | out_ready_i;
  assign fire       = in_valid_i & in_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q   <= 1'b0;
      illegal_q <= 1'b0;
      we_q      <= 1'b0;
      res_q     <= '0;
      cr_q      <= '0;
    end else begin
      illegal_q <= fire & ~legal;
      if (fire) begin
        valid_q <= legal;
        if (legal) begin
          res_q <= sum;
          cr_q  <= cr_next;
          we_q  <= rc;
        end
      end else if (out_ready_i) begin
        valid_q <= 1'b0;
      end
    end
  end

  assign out_valid_o = valid_q;
  assign res_o       = res_q;
  assign cr_o        = cr_q;
  assign cr_we_o     = we_q;
  assign illegal_o   = illegal_q;

  a_r9_hold_stalled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(res_o) && $stable(cr_o) && $stable(cr_we_o));

  a_r9_idle_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_valid_o |-> in_ready_o);

  a_r7_illegal_no_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> !out_valid_o);

  a_r7_illegal_after_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> $past(fire));

  a_r8_one_sign_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> $countones(cr_o[3:1]) == 1);

  a_r8_eq_means_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && cr_o[1] |-> res_o == '0);
endmodule

// File: tb/scaled_add_unit_bench.sv
`timescale 1ns/1ps
module scaled_add_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [10:0] xo = '0;
  logic [63:0] a = '0, b = '0;
  logic        so = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] res;
  logic [3:0]  cr;
  logic        cr_we, illegal;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  scaled_add_unit u_scaled_add_unit (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .xo_i(xo), .a_i(a), .b_i(b), .so_i(so), .out_valid_o(out_valid),
    .out_ready_i(out_ready), .res_o(res), .cr_o(cr), .cr_we_o(cr_we),
    .illegal_o(illegal)
  );

  localparam logic [7:0] C_FULL = 8'b01101110;
  localparam logic [7:0] C_SW   = 8'b10101110;
  localparam logic [7:0] C_UW   = 8'b11101110;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] model(input int v, input int sh, input logic [63:0] av, input logic [63:0] bv);
    logic [63:0] op;
    if (v == 1) op = {{32{bv[31]}}, bv[31:0]};
    else if (v == 2) op = {32'h0, bv[31:0]};
    else op = bv;
    return op * (64'd2 << sh) + av;
  endfunction

  function automatic logic [3:0] model_cr(input logic [63:0] r, input logic s);
    logic neg, zero;
    neg  = r[63];
    zero = (r == 64'h0);
    return {neg, !neg && !zero, zero, s};
  endfunction

  task automatic issue(input logic [10:0] x, input logic [63:0] av, input logic [63:0] bv, input logic s);
    @(negedge clk);
    in_valid = 1'b1; xo = x; a = av; b = bv; so = s;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic run_one(input int v, input int sh, input logic [63:0] av, input logic [63:0] bv, input logic s, input logic rc, input string req);
    logic [7:0]  code;
    logic [63:0] e;
    code = (v == 0) ? C_FULL : (v == 1) ? C_SW : C_UW;
    issue({sh[1:0], code, rc}, av, bv, s);
    e = model(v, sh, av, bv);
    check(out_valid == 1'b1, {req, " valid"}, {63'h0, out_valid}, 64'h1);
    check(res == e, {req, " result"}, res, e);
    check(cr == model_cr(e, s), "R8 cr", {60'h0, cr}, {60'h0, model_cr(e, s)});
    check(cr_we == rc, "R8 cr_we", {63'h0, cr_we}, {63'h0, rc});
  endtask

  initial begin
    logic [63:0] bvals [4];
    logic [63:0] avals [2];
    logic [63:0] r_ref;
    bvals[0] = 64'habadbabedefec8ed;
    bvals[1] = 64'h123456780000abcd;
    bvals[2] = 64'h0000000080000001;
    bvals[3] = 64'hffffffff7ffffff3;
    avals[0] = 64'hf00dcafedeadbeef;
    avals[1] = 64'h0000000000000005;

    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check(out_valid == 1'b0, "R1 out_valid", {63'h0, out_valid}, 64'h0);
    check(illegal == 1'b0, "R1 illegal", {63'h0, illegal}, 64'h0);
    check(in_ready == 1'b1, "R1 in_ready", {63'h0, in_ready}, 64'h1);
    rst_n = 1'b1;

    // R2 R3 R4 R5: all variants x all SH x B/A patterns (incl. wrap past 2^64)
    for (int v = 0; v < 3; v++)
      for (int sh = 0; sh < 4; sh++)
        for (int bi = 0; bi < 4; bi++)
          for (int ai = 0; ai < 2; ai++)
            run_one(v, sh, avals[ai], bvals[bi], 1'(bi & 1), 1'(ai ^ sh[0]),
                    v == 0 ? "R2 R3" : v == 1 ? "R2 R4" : "R2 R5");

    // R6: upper half of B ignored by word variants
    for (int v = 1; v < 3; v++)
      for (int sh = 0; sh < 4; sh++) begin
        logic [7:0] code;
        code = (v == 1) ? C_SW : C_UW;
        issue({sh[1:0], code, 1'b1}, 64'h1111, 64'h0000000080000010, 1'b0);
        r_ref = res;
        issue({sh[1:0], code, 1'b1}, 64'h1111, 64'hdeadbeef80000010, 1'b0);
        check(res == r_ref, "R6 upper B ignored", res, r_ref);
        check(cr == model_cr(r_ref, 1'b0), "R6 cr unchanged", {60'h0, cr}, {60'h0, model_cr(r_ref, 1'b0)});
      end

    // R8: exact zero result sets EQ
    run_one(0, 0, 64'hfffffffffffffffe, 64'h1, 1'b1, 1'b1, "R8 zero");
    check(cr == 4'b0011, "R8 eq flag", {60'h0, cr}, 64'h3);

    // R7: illegal variants
    for (int k = 0; k < 3; k++) begin
      logic [7:0] bad;
      bad = (k == 0) ? 8'h00 : (k == 1) ? 8'b01101111 : 8'b00101110;
      issue({2'b01, bad, 1'b1}, 64'h5, 64'h7, 1'b0);
      check(illegal == 1'b1, "R7 illegal pulse", {63'h0, illegal}, 64'h1);
      check(out_valid == 1'b0, "R7 no valid", {63'h0, out_valid}, 64'h0);
      @(negedge clk);
      check(illegal == 1'b0, "R7 single cycle", {63'h0, illegal}, 64'h0);
    end

    // R9: stall holds result and drops ready
    out_ready = 1'b0;
    issue({2'b11, C_FULL, 1'b0}, 64'h100, 64'h3, 1'b0);
    r_ref = model(0, 3, 64'h100, 64'h3);
    check(res == r_ref, "R9 result", res, r_ref);
    check(in_ready == 1'b0, "R9 ready low", {63'h0, in_ready}, 64'h0);
    repeat (3) @(negedge clk);
    check(out_valid == 1'b1, "R9 held valid", {63'h0, out_valid}, 64'h1);
    check(res == r_ref, "R9 held result", res, r_ref);
    out_ready = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R9 released", {63'h0, out_valid}, 64'h0);
    check(in_ready == 1'b1, "R9 ready back", {63'h0, in_ready}, 64'h1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%h expected=%h", 64'h0, 64'h1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule